// File: doc/BRIEF.md
# Divider Setting Loader with Serial and Parallel Paths

This block keeps the configuration of a clock synthesizer: a 9-bit feedback multiplier value, a 2-bit output divide code and a 2-bit test selector. Two independent loading paths feed it. A parallel path exposes the multiplier and divide pins directly, gated by a low-active strobe. A serial path collects a 14-bit frame bit by bit under a serial clock and moves it into the settings under control of a serial load pin.

The strobe and the serial pins are asynchronous to the system clock. Each passes through a synchronizer chain, and its edges are detected in the system clock domain. While the strobe is low, the settings are transparent to the pins. A rising edge of the strobe freezes them. After a system reset the settings also track the pins until the first latch event of either kind, so board-level pin straps act as the power-up configuration.

A test pin is driven from one of four sources, picked by the stored test selector, and is held low whenever the parallel path is active. Where this document counts cycles, it means system clock cycles.

Top module: `divcfg_loader`

## Requirements
- R1: While the parallel strobe `pLoadN` is low, `mSet` and `nSet` follow `pinM` and `pinN` within four cycles of any change.
- R2: A rising edge of `pLoadN` latches `mSet` and `nSet`. The pins must be stable for three cycles after that edge. While `pLoadN` stays high and `sLoad` stays low, later pin changes have no effect on the settings.
- R3: After system reset, while `pLoadN` is high, the settings follow the pins. This lasts until the first rising edge of `pLoadN` or of `sLoad`.
- R4: While `pLoadN` is high, every rising edge of `sClk` shifts `sData` into the least significant end of a 14-bit register. The frame is sent first bit first, in this order: test bit 1, test bit 0, a dummy bit, divide bit 1, divide bit 0, then multiplier bits 8 down to 0.
- R5: A rising edge of `sLoad` with `pLoadN` high copies the frame fields into `tSet`, `nSet` and `mSet`. After `sLoad` falls, further serial clocks leave the settings unchanged.
- R6: While `sLoad` is high and `pLoadN` is high, each rising `sClk` edge updates the settings with the newly shifted frame contents.
- R7: `testOut` depends on `tSet`. Code 0 gives constant low. Code 1 gives the bit at the output end of the shift register, which is the oldest of the last 14 bits shifted. Code 2 gives `mDivIn`. Code 3 gives `halfClkIn`.
- R8: `testOut` is low while `pLoadN` is low, whatever `tSet` holds, and `tSet` is not changed by the parallel path.
- R9: System reset clears `tSet` to 0 and the shift register to all zeros.
- R10: Rising `sClk` edges while `pLoadN` is low do not alter the shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| pLoadN | input | 1 | Parallel strobe, low means transparent |
| pinM | input | 9 | Parallel multiplier pins |
| pinN | input | 2 | Parallel divide-code pins |
| sClk | input | 1 | Serial shift clock (asynchronous) |
| sData | input | 1 | Serial data |
| sLoad | input | 1 | Serial transfer control |
| mDivIn | input | 1 | Feedback divider output, for observation |
| halfClkIn | input | 1 | Half-rate output clock, for observation |
| mSet | output | 9 | Current multiplier setting |
| nSet | output | 2 | Current divide code |
| tSet | output | 2 | Current test selector |
| testOut | output | 1 | Test pin |

## Verification
The bench builds the block with its default widths: a 9-bit multiplier, a 2-bit divide code and two synchronizer stages. At these widths a complete sweep of all 2048 parallel pin combinations is practical. Serial frames cover every test and divide code against a spread of multiplier values, and the expected fields are derived arithmetically from each frame. The bench keeps its own model of the shift register, which lets it predict the test pin in shift-output mode and check flow-through updates bit by bit.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  typedef struct packed {
    logic loadPins;  // settings take the parallel pins
    logic shift;     // shift register advances one bit
    logic xfer;      // settings take frame contents
    logic serBit;    // synchronized serial data
    logic parMode;   // parallel path active
  } cfgStrobe_t;
endpackage

// File: rtl/divcfg_ctl.sv
module divcfg_ctl
  import divcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pLoadN,
  input  logic       sClk,
  input  logic       sData,
  input  logic       sLoad,
  output cfgStrobe_t strb
);
  localparam int NSIG = 4;
  // bit 3: strobe (resets high so reset release makes no edge), 2: sClk, 1: sData, 0: sLoad
  localparam logic [NSIG-1:0] SYNC_RST = 4'b1000;

  logic [NSIG-1:0] rawIn;
  logic [SYNC_STAGES-1:0][NSIG-1:0] syncQ;
  logic [NSIG-1:0] syncNow, prevQ;
  logic follow;

  assign rawIn = {pLoadN, sClk, sData, sLoad};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= SYNC_RST;
        else       syncQ[g] <= rawIn;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= SYNC_RST;
        else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign syncNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= SYNC_RST;
    else       prevQ <= syncNow;

  logic plHigh, plRise, clkRise, ldHigh, ldRise, xferNow;
  assign plHigh  = syncNow[3];
  assign plRise  = syncNow[3] & ~prevQ[3];
  assign clkRise = syncNow[2] & ~prevQ[2];
  assign ldHigh  = syncNow[0];
  assign ldRise  = syncNow[0] & ~prevQ[0];
  assign xferNow = plHigh & (ldRise | (ldHigh & clkRise));

  // power-up transparency until first latch event
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                 follow <= 1'b1;
    else if (plRise | xferNow) follow <= 1'b0;

  always_comb begin
    strb.parMode  = ~plHigh;
    strb.shift    = plHigh & clkRise;
    strb.xfer     = xferNow;
    strb.loadPins = (~plHigh | follow) & ~xferNow;
    strb.serBit   = syncNow[1];
  end
endmodule

// File: rtl/divcfg_dp.sv
module divcfg_dp
  import divcfg_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  cfgStrobe_t     strb,
  input  logic [M_W-1:0] pinM,
  input  logic [N_W-1:0] pinN,
  input  logic           mDivIn,
  input  logic           halfClkIn,
  output logic [M_W-1:0] mSet,
  output logic [N_W-1:0] nSet,
  output logic [T_W-1:0] tSet,
  output logic           testOut
);
  localparam int FRAME_W = T_W + 1 + N_W + M_W;
  localparam int N_LO    = M_W;
  localparam int T_LO    = M_W + N_W + 1;

  logic [FRAME_W-1:0] shreg, shNext, src;

  assign shNext = {shreg[FRAME_W-2:0], strb.serBit};
  assign src    = strb.shift ? shNext : shreg;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           shreg <= '0;
    else if (strb.shift) shreg <= shNext;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      mSet <= '0;
      nSet <= '0;
      tSet <= '0;
    end else if (strb.xfer) begin
      mSet <= src[M_W-1:0];
      nSet <= src[N_LO +: N_W];
      tSet <= src[T_LO +: T_W];
    end else if (strb.loadPins) begin
      mSet <= pinM;
      nSet <= pinN;
    end

  always_comb begin
    case (tSet)
      2'd1:    testOut = shreg[FRAME_W-1];
      2'd2:    testOut = mDivIn;
      2'd3:    testOut = halfClkIn;
      default: testOut = 1'b0;
    endcase
    if (strb.parMode) testOut = 1'b0;
  end

  // R1: pin transparency reaches the settings one cycle later
  a_r1_pins_flow: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPins |=> (mSet == $past(pinM) && nSet == $past(pinN)));

  // R2: with no load request the settings stay put
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadPins && !strb.xfer) |=> ($stable(mSet) && $stable(nSet)));

  // R4: each shift enters the new bit at the low end
  a_r4_shift_order: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> shreg == {$past(shreg[FRAME_W-2:0]), $past(strb.serBit)});

  // R8: test selector changes only on a serial transfer
  a_r8_tsel_keep: assert property (@(posedge clk) disable iff (!rstN)
    !strb.xfer |=> $stable(tSet));
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pLoadN,
  input  logic [M_W-1:0] pinM,
  input  logic [N_W-1:0] pinN,
  input  logic           sClk,
  input  logic           sData,
  input  logic           sLoad,
  input  logic           mDivIn,
  input  logic           halfClkIn,
  output logic [M_W-1:0] mSet,
  output logic [N_W-1:0] nSet,
  output logic [1:0]     tSet,
  output logic           testOut
);
  cfgStrobe_t strb;

  divcfg_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .pLoadN(pLoadN), .sClk(sClk),
    .sData(sData), .sLoad(sLoad), .strb(strb)
  );

  divcfg_dp #(.M_W(M_W), .N_W(N_W), .T_W(2)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pinM(pinM), .pinN(pinN),
    .mDivIn(mDivIn), .halfClkIn(halfClkIn), .mSet(mSet), .nSet(nSet),
    .tSet(tSet), .testOut(testOut)
  );
endmodule

// File: tb/divcfg_loader_bench.sv
module divcfg_loader_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0, pLoadN = 1'b1, sClk = 1'b0, sData = 1'b0, sLoad = 1'b0;
  logic mDivIn = 1'b1, halfClkIn = 1'b1;
  logic [8:0] pinM = 9'h0A5;
  logic [1:0] pinN = 2'd2;
  logic [8:0] mSet;
  logic [1:0] nSet, tSet;
  logic testOut;

  int checks = 0, fails = 0, cycles = 0;
  logic [13:0] expSh = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  divcfg_loader u_divcfg_loader (
    .clk(clk), .rstN(rstN), .pLoadN(pLoadN), .pinM(pinM), .pinN(pinN),
    .sClk(sClk), .sData(sData), .sLoad(sLoad), .mDivIn(mDivIn),
    .halfClkIn(halfClkIn), .mSet(mSet), .nSet(nSet), .tSet(tSet),
    .testOut(testOut)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkSet(input string req, input logic [8:0] m, input logic [1:0] n, input logic [1:0] t);
    chk(req, 32'(mSet), 32'(m));
    chk(req, 32'(nSet), 32'(n));
    chk(req, 32'(tSet), 32'(t));
  endtask

  task automatic sendBit(input logic b, input bit counted);
    sData = b; tick(4);
    sClk = 1'b1; tick(4);
    sClk = 1'b0; tick(4);
    if (counted) expSh = {expSh[12:0], b};
  endtask

  task automatic sendFrame(input logic [1:0] t, input logic [1:0] n, input logic [8:0] m);
    logic [13:0] f;
    f = {t, 1'b0, n, m};
    for (int i = 13; i >= 0; i--) sendBit(f[i], 1'b1);
  endtask

  task automatic loadPulse();
    sLoad = 1'b1; tick(6);
    sLoad = 1'b0; tick(6);
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(6);
    // R3: power-up transparency with strobe high
    chkSet("R3 default follow", 9'h0A5, 2'd2, 2'd0);
    // R9: test selector cleared -> constant low even with sources high
    chk("R9 reset test low", 32'(testOut), 32'd0);
    pinM = 9'h13C; pinN = 2'd1; tick(6);
    chkSet("R3 still follows", 9'h13C, 2'd1, 2'd0);

    // R9: transfer of untouched shift register yields zeros
    sLoad = 1'b1; tick(6);
    chkSet("R9 shift reg cleared", 9'h000, 2'd0, 2'd0);
    sLoad = 1'b0; tick(6);
    pinM = 9'h1FF; pinN = 2'd3; tick(6);
    chkSet("R3 follow ends at latch", 9'h000, 2'd0, 2'd0);

    // R1: exhaustive parallel transparency
    pLoadN = 1'b0; tick(6);
    for (int v = 0; v < 2048; v++) begin
      pinM = v[8:0]; pinN = v[10:9];
      tick(2);
      chk("R1 transparent M", 32'(mSet), 32'(v % 512));
      chk("R1 transparent N", 32'(nSet), 32'(v / 512));
    end

    // R2: latch on strobe rise, later pin changes ignored
    for (int k = 0; k < 8; k++) begin
      pLoadN = 1'b0;
      pinM = 9'((k * 71 + 13) % 512); pinN = 2'(k % 4);
      tick(6);
      pLoadN = 1'b1; tick(6);
      pinM = ~pinM; pinN = ~pinN; tick(6);
      chk("R2 held M", 32'(mSet), 32'((k * 71 + 13) % 512));
      chk("R2 held N", 32'(nSet), 32'(k % 4));
    end

    // R4/R5: serial frames over all test and divide codes
    for (int ti = 0; ti < 4; ti++)
      for (int ni = 0; ni < 4; ni++)
        for (int mi = 0; mi < 6; mi++) begin
          logic [8:0] mv;
          logic [8:0] pm; logic [1:0] pn; logic [1:0] pt;
          mv = 9'((mi * 83 + ti * 29 + ni * 7) % 512);
          pm = mSet; pn = nSet; pt = tSet;
          sendFrame(2'(ti), 2'(ni), mv);
          chkSet("R5 no change before load", pm, pn, pt);
          sLoad = 1'b1; tick(6);
          chkSet("R4 R5 frame fields", mv, 2'(ni), 2'(ti));
          sLoad = 1'b0; tick(6);
          sendBit(1'b1, 1'b1);
          chkSet("R5 hold after fall", mv, 2'(ni), 2'(ti));
        end

    // R6: flow-through while serial load high
    sendFrame(2'd0, 2'd1, 9'h0C3);
    sLoad = 1'b1; tick(6);
    for (int i = 0; i < 14; i++) begin
      sendBit((i % 3) == 0, 1'b1);
      chkSet("R6 flow-through", expSh[8:0], expSh[10:9], expSh[13:12]);
    end
    sLoad = 1'b0; tick(6);

    // R7: code 1 shows oldest bit of the shift register
    sendFrame(2'd1, 2'd2, 9'h055);
    loadPulse();
    chk("R7 code1 msb", 32'(testOut), 32'(expSh[13]));
    for (int i = 0; i < 4; i++) begin
      sendBit(i[0], 1'b1);
      chk("R7 code1 shifting", 32'(testOut), 32'(expSh[13]));
    end
    // R7: code 2 follows divider input
    sendFrame(2'd2, 2'd0, 9'h011);
    loadPulse();
    mDivIn = 1'b0; tick(1); chk("R7 code2 low", 32'(testOut), 32'd0);
    mDivIn = 1'b1; tick(1); chk("R7 code2 high", 32'(testOut), 32'd1);
    // R7: code 0 constant low
    sendFrame(2'd0, 2'd0, 9'h011);
    loadPulse();
    chk("R7 code0 low", 32'(testOut), 32'd0);
    // R7: code 3 follows half-rate clock
    sendFrame(2'd3, 2'd3, 9'h01C);
    loadPulse();
    halfClkIn = 1'b0; tick(1); chk("R7 code3 low", 32'(testOut), 32'd0);
    halfClkIn = 1'b1; tick(1); chk("R7 code3 high", 32'(testOut), 32'd1);

    // R8: parallel mode silences test pin, selector kept
    pinM = 9'h0AA; pinN = 2'd1;
    pLoadN = 1'b0; tick(6);
    chk("R8 forced low", 32'(testOut), 32'd0);
    chk("R8 selector kept", 32'(tSet), 32'd3);

    // R10: serial clocks during parallel mode do not shift
    sendBit(1'b1, 1'b0);
    sendBit(1'b0, 1'b0);
    sendBit(1'b1, 1'b0);
    pLoadN = 1'b1; tick(6);
    chk("R8 test back", 32'(testOut), 32'd1);
    sLoad = 1'b1; tick(6);
    chkSet("R10 shift reg intact", expSh[8:0], expSh[10:9], expSh[13:12]);
    sLoad = 1'b0; tick(6);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (!done && cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end
endmodule